// File: doc/BRIEF.md
# Dual-Port Serial Bit-Rate Tick Generator

This block makes the oversampling strobes for two serial ports from one core clock. Each output is a single-cycle pulse at sixteen times the wanted bit rate. The receivers and transmitters that sit behind the block count these pulses to frame their bits.

Port 0 has two possible clock sources, chosen by a select pin:
- A 10-bit reload divider, scaled by a fixed factor of 64.
- The overflow of an 8-bit auto-reload timer, scaled by a fixed factor of 384.

A doubling pin halves the fixed scale of whichever source port 0 is using. Port 1 always has its own 10-bit reload divider, scaled by 32, and the doubling pin has no effect on it.

Each 10-bit reload value arrives as a low byte and a two-bit high part. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain level control, sampled on each clock edge. Both sources for port 0 run all the time, and the select pin only chooses which one drives the output.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, both tick outputs are 0.
- R2: With port 0 on the internal source (select = 1) and doubling = 1, tick0 repeats every 2·(1024 − R0) cycles. R0 = {hi[1:0], lo[7:0]}.
- R3: With port 0 on the internal source and doubling = 0, tick0 repeats every 4·(1024 − R0) cycles. This gives a bit rate of fclk/(64·(1024 − R0)).
- R4: With port 0 on the timer source (select = 0), tick0 repeats every 24·(256 − T) cycles when doubling = 0, and every 12·(256 − T) cycles when doubling = 1.
- R5: tick1 repeats every 2·(1024 − R1) cycles, whatever the select and doubling pins are set to.
- R6: Each 10-bit reload value is formed with the two-bit high input as bits 9:8 and the low byte as bits 7:0.
- R7: A reload value that changes in the middle of a count is used only from the next wrap of that counter. The interval already running completes with the old value.
- R8: Every tick is a single-cycle strobe. No tick output is high on two cycles in a row.
- R9: The largest reload (1023, or 255 for the timer) gives the fastest rate: 2 cycles for the dividers when doubling applies, and 12 cycles for the timer with doubling. No reload value makes a divider stop.
- R10: Both port-0 sources keep counting while they are not selected. After the select pin changes, tick0 immediately follows the newly chosen source's running schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Port 0 source: 1 selects the internal divider, 0 selects the timer |
| dbl_i | input | 1 | Doubles the port 0 rate |
| rl0_lo_i | input | 8 | Port 0 divider reload, bits 7:0 |
| rl0_hi_i | input | 2 | Port 0 divider reload, bits 9:8 |
| rl1_lo_i | input | 8 | Port 1 divider reload, bits 7:0 |
| rl1_hi_i | input | 2 | Port 1 divider reload, bits 9:8 |
| tmr_rl_i | input | 8 | Timer reload value |
| tick0_o | output | 1 | Port 0 oversampling strobe |
| tick1_o | output | 1 | Port 1 oversampling strobe |

## Verification
The bench targets these corner cases, each paired with the way a wrong design would show itself:
- **Reload change in the middle of a count.** A design that loaded the new value at once would shorten the interval already under way.
- **Largest reload values.** An off-by-one in the wrap compare would show up here as a stalled divider or a doubled period.
- **Doubling and select changes while running.** A design that shared one halving stage between the two sources, or that restarted a counter on a select change, would produce tick0 intervals that do not match either source's schedule.
- **High reload part.** A swapped or mis-positioned high part gives a period far from 2·(1024 − R).

// File: rtl/btg_pkg.sv
package btg_pkg;
  typedef enum logic {
    BTG_SRC_TIMER    = 1'b0,
    BTG_SRC_INTERNAL = 1'b1
  } btg_src_e;
  localparam int unsigned BTG_LO_W = 8;
endpackage

// File: rtl/btg_prescaler.sv
module btg_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign step_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R2: a prescaled step never occurs on two adjacent cycles
      a_r2_step_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> !step_o);
    end
  endgenerate
endmodule

// File: rtl/btg_reload_ctr.sv
module btg_reload_ctr #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] reload_i,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= TOP;
    else if (step_i) begin
      if (cnt_q == TOP) cnt_q <= reload_i;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wrap_o = step_i && (cnt_q == TOP);

  // R7: the reload value is captured only at a wrap
  a_r7_load_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(reload_i)));

  // R7: between steps the count holds, whatever the reload input does
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/btg_halver.sv
module btg_halver (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic bypass_i,
  output logic pulse_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= 1'b0;
    else if (pulse_i) ph_q <= ~ph_q;
  end

  assign pulse_o = pulse_i && (bypass_i || ph_q);

  // R3: the phase flips on every incoming pulse
  a_r3_phase_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> (ph_q != $past(ph_q)));

  // R3: no output without an incoming pulse
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |-> !pulse_o);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned TMR_W   = 8,
  parameter int unsigned DIV_PRE = 2,
  parameter int unsigned TMR_PRE = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         src_sel_i,
  input  logic                         dbl_i,
  input  logic [btg_pkg::BTG_LO_W-1:0] rl0_lo_i,
  input  logic [DIV_W-btg_pkg::BTG_LO_W-1:0] rl0_hi_i,
  input  logic [btg_pkg::BTG_LO_W-1:0] rl1_lo_i,
  input  logic [DIV_W-btg_pkg::BTG_LO_W-1:0] rl1_hi_i,
  input  logic [TMR_W-1:0]             tmr_rl_i,
  output logic                         tick0_o,
  output logic                         tick1_o
);
  import btg_pkg::*;

  logic [DIV_W-1:0] reload0, reload1;
  logic             div_step, tmr_step;
  logic             wrap0, wrap1, wrap_t;
  logic             half0, half_t;
  btg_src_e         src;

  assign reload0 = {rl0_hi_i, rl0_lo_i};
  assign reload1 = {rl1_hi_i, rl1_lo_i};
  assign src     = btg_src_e'(src_sel_i);

  btg_prescaler #(.DIV(DIV_PRE)) u_pre_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_o(div_step));

  btg_prescaler #(.DIV(TMR_PRE)) u_pre_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_o(tmr_step));

  btg_reload_ctr #(.W(DIV_W)) u_ctr0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(div_step),
    .reload_i(reload0), .wrap_o(wrap0));

  btg_reload_ctr #(.W(DIV_W)) u_ctr1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(div_step),
    .reload_i(reload1), .wrap_o(wrap1));

  btg_reload_ctr #(.W(TMR_W)) u_ctr_t (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(tmr_step),
    .reload_i(tmr_rl_i), .wrap_o(wrap_t));

  btg_halver u_half0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(wrap0),
    .bypass_i(dbl_i), .pulse_o(half0));

  btg_halver u_half_t (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(wrap_t),
    .bypass_i(dbl_i), .pulse_o(half_t));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick0_o <= 1'b0;
      tick1_o <= 1'b0;
    end else begin
      tick0_o <= (src == BTG_SRC_INTERNAL) ? half0 : half_t;
      tick1_o <= wrap1;
    end
  end

  // R8: strobes last exactly one cycle
  a_r8_tick0_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick0_o |=> !tick0_o);
  a_r8_tick1_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick1_o |=> !tick1_o);

  // R10: the unselected source never reaches tick0
  a_r10_timer_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == BTG_SRC_TIMER && !half_t) |=> !tick0_o);

  // R5: port 1 pulses only after its own divider wrapped
  a_r5_tick1_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick1_o |-> $past(wrap1));
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       src_sel = 1'b1;
  logic       dbl = 1'b1;
  logic [7:0] rl0_lo = 8'hFC;
  logic [1:0] rl0_hi = 2'd3;
  logic [7:0] rl1_lo = 8'hFC;
  logic [1:0] rl1_hi = 2'd3;
  logic [7:0] tmr_rl = 8'hFE;
  logic       tick0, tick1;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  baud_tick_gen i_baud_tick_gen (
    .clk_i(clk), .rst_ni(rst_ni), .src_sel_i(src_sel), .dbl_i(dbl),
    .rl0_lo_i(rl0_lo), .rl0_hi_i(rl0_hi), .rl1_lo_i(rl1_lo), .rl1_hi_i(rl1_hi),
    .tmr_rl_i(tmr_rl), .tick0_o(tick0), .tick1_o(tick1));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: each counter tracked as "steps left until wrap".
  int  m_pre_div = 0, m_pre_tmr = 0;
  int  m_left0 = 1, m_left1 = 1, m_left_t = 1;
  bit  m_ph0 = 0, m_ph_t = 0;
  bit  m_tick0 = 0, m_tick1 = 0;
  bit  prev0 = 0, prev1 = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_ni) begin
      m_pre_div = 0; m_pre_tmr = 0;
      m_left0 = 1; m_left1 = 1; m_left_t = 1;
      m_ph0 = 0; m_ph_t = 0; m_tick0 = 0; m_tick1 = 0;
    end else begin
      bit sd, st, w0, w1, wt, h0, ht;
      sd = (m_pre_div == 1);
      st = (m_pre_tmr == 11);
      w0 = sd && (m_left0 == 1);
      w1 = sd && (m_left1 == 1);
      wt = st && (m_left_t == 1);
      if (sd) begin
        m_left0 = (m_left0 == 1) ? 1024 - int'({rl0_hi, rl0_lo}) : m_left0 - 1;
        m_left1 = (m_left1 == 1) ? 1024 - int'({rl1_hi, rl1_lo}) : m_left1 - 1;
      end
      if (st) m_left_t = (m_left_t == 1) ? 256 - int'(tmr_rl) : m_left_t - 1;
      h0 = w0 && (dbl || m_ph0);
      ht = wt && (dbl || m_ph_t);
      if (w0) m_ph0 = !m_ph0;
      if (wt) m_ph_t = !m_ph_t;
      m_tick0 = src_sel ? h0 : ht;
      m_tick1 = w1;
      m_pre_div = (m_pre_div + 1) % 2;
      m_pre_tmr = (m_pre_tmr + 1) % 12;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_ni) begin
      vectors++;
      if (tick0 !== m_tick0) begin
        errors++;
        $display("FAIL %s tick0 actual=%0b expected=%0b", src_sel ? "R2" : "R4", tick0, m_tick0);
      end
      vectors++;
      if (tick1 !== m_tick1) begin
        errors++;
        $display("FAIL R5 tick1 actual=%0b expected=%0b", tick1, m_tick1);
      end
      vectors++;
      if ((tick0 && prev0) || (tick1 && prev1)) begin
        errors++;
        $display("FAIL R8 strobe held actual=%0b%0b expected=0", tick0 && prev0, tick1 && prev1);
      end
      prev0 = tick0; prev1 = tick1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(input bit port);
    do @(negedge clk); while (!(port ? tick1 : tick0));
  endtask

  task automatic measure(input bit port, input int exp, input string tag);
    int n;
    wait_pulse(port);
    n = 0;
    do begin @(negedge clk); n++; end while (!(port ? tick1 : tick0));
    check(tag, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tick0 in reset", int'(tick0), 0);
    check("R1 tick1 in reset", int'(tick1), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 tick0 after release", int'(tick0), 0);
    check("R1 tick1 after release", int'(tick1), 0);

    // R2 / R5: reload 1020, doubling on
    measure(1'b0, 8, "R2 internal doubled");
    measure(1'b1, 8, "R5 port1 period");
    // R3: doubling off
    dbl = 1'b0;
    @(negedge clk);
    measure(1'b0, 16, "R3 internal undoubled");
    measure(1'b1, 8, "R5 port1 ignores doubling");
    // R6: high part placement
    rl0_lo = 8'hF8; rl0_hi = 2'd3; dbl = 1'b1;
    measure(1'b0, 16, "R6 reload 1016");
    rl1_lo = 8'hFF; rl1_hi = 2'd2;
    measure(1'b1, 2 * (1024 - 767), "R6 reload 767");
    // R7: change mid-count
    rl1_lo = 8'h9C; rl1_hi = 2'd3;
    wait_pulse(1'b1);
    measure(1'b1, 200, "R7 reload 924");
    wait_pulse(1'b1);
    repeat (10) @(negedge clk);
    rl1_lo = 8'hFC;
    begin
      int n;
      n = 10;
      do begin @(negedge clk); n++; end while (!tick1);
      check("R7 running interval keeps old reload", n, 200);
    end
    measure(1'b1, 8, "R7 new reload after wrap");
    // R4: timer source
    src_sel = 1'b0; tmr_rl = 8'hFE; dbl = 1'b1;
    measure(1'b0, 24, "R4 timer doubled");
    dbl = 1'b0;
    @(negedge clk);
    measure(1'b0, 48, "R4 timer undoubled");
    measure(1'b1, 8, "R5 port1 ignores select");
    // R9: fastest settings
    dbl = 1'b1; tmr_rl = 8'hFF;
    wait_pulse(1'b0);
    measure(1'b0, 12, "R9 timer max reload");
    rl1_lo = 8'hFF; rl1_hi = 2'd3;
    wait_pulse(1'b1);
    measure(1'b1, 2, "R9 port1 max reload");
    src_sel = 1'b1; rl0_lo = 8'hFF; rl0_hi = 2'd3;
    wait_pulse(1'b0);
    measure(1'b0, 2, "R9 port0 max reload");
    // R10: select flip while both sources run
    rl0_lo = 8'hF0;
    repeat (80) @(negedge clk);
    src_sel = 1'b0;
    measure(1'b0, 12, "R10 timer schedule after select change");
    src_sel = 1'b1;
    measure(1'b0, 32, "R10 internal schedule after select change");
    repeat (50) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    errors++;
    $display("FAIL watchdog actual=%0d cycles expected<%0d", cycles, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule